// File: doc/BRIEF.md
# Multi-dimensional table address mapper

This block holds a small constant table that is logically two- or three-dimensional and stores it in a one-dimensional synchronous memory. A requester presents a coordinate triple (x, y, z) with a valid strobe. The block checks each coordinate against its declared extent and turns the triple into a linear memory address. It then reads the table and returns the stored word, the address it used and an error flag. A two-dimensional table is built by setting the z extent to one.

A parameter picks one of two storage layouts for the same logical table. The padded layout rounds every extent up to a power of two and forms the address by bit concatenation. It needs no arithmetic, but the unused slots waste memory. The dense layout packs the entries with no gaps and forms a mixed-radix address from multiplications by constants and additions. The table contents come from a function evaluated at elaboration, so both layouts return identical words for identical coordinates. The block accepts one request per cycle and has a fixed latency of two cycles: the address is registered first, and the memory read is registered in the next cycle.

Top module: `tbl_map`

## Requirements
- R1: `rsp_valid_o` is high exactly two clock edges after an edge that sampled `req_valid_i` high, and is low in every other cycle.
- R2: In the dense layout, an in-range request reports `rsp_addr_o` = x·(DIM_Y·DIM_Z) + y·DIM_Z + z. For 3×4×5 this is 20x + 5y + z.
- R3: In the padded layout, each coordinate field is ceil(log2(extent)) bits wide, with a minimum of 1. An in-range request reports `rsp_addr_o` = {x, y, z}, with x in the upper bits. The z field is left out when DIM_Z = 1. For 3×4×5 the address is {x[1:0], y[1:0], z[2:0]}, and for a 3×3 grid it is {row[1:0], col[1:0]}.
- R4: For an in-range request, `rsp_data_o` = (x·64 + y·8 + z + 1) truncated to DATA_W bits, in both layouts.
- R5: If any coordinate is greater than or equal to its extent, the response has `rsp_err_o` = 1, `rsp_addr_o` = 0 and `rsp_data_o` = 0.
- R6: If every coordinate is within its extent, the response has `rsp_err_o` = 0.
- R7: While `rst_ni` is low, `rsp_valid_o` is low. A request that is in flight when reset is asserted never produces a response.
- R8: Requests on consecutive cycles are all accepted. Each request produces its own response, and the responses come out in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_x_i | input | XW | x coordinate (outermost) |
| req_y_i | input | YW | y coordinate |
| req_z_i | input | ZW | z coordinate (innermost) |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Coordinate out of range |
| rsp_addr_o | output | AW | Linear address used for the read |
| rsp_data_o | output | DATA_W | Table word |

## Verification
A wrong stride or a wrong field order in the address stage shows up on `rsp_addr_o` two cycles after the request. A faulty extent compare shows up at the same point, as a wrong `rsp_err_o` together with a zeroed or non-zero word. A memory slot that is decoded from the wrong coordinates returns a word that does not match the coordinate formula on the same response. A lost or duplicated valid bit makes responses fall out of step with a back-to-back request stream within one cycle. The bench runs three configurations together so that the dense layout, the padded layout and the dropped-z case are each compared against independent arithmetic.

// File: rtl/tbl_map_pkg.sv
package tbl_map_pkg;

  typedef enum logic {
    LAYOUT_PADDED = 1'b0,
    LAYOUT_DENSE  = 1'b1
  } tbl_layout_e;

  // Logical table contents, shared by every layout.
  function automatic int tbl_word(input int x, input int y, input int z);
    return x * 64 + y * 8 + z + 1;
  endfunction

endpackage

// File: rtl/tbl_addr_stage.sv
module tbl_addr_stage
  import tbl_map_pkg::*;
#(
  parameter tbl_layout_e LAYOUT = LAYOUT_DENSE,
  parameter int DIM_X = 3,
  parameter int DIM_Y = 4,
  parameter int DIM_Z = 5,
  parameter int XW    = 2,
  parameter int YW    = 2,
  parameter int ZW    = 3,
  parameter int ZWU   = 3,
  parameter int AW    = 6,
  parameter int DEPTH = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [ZW-1:0] z_i,
  output logic          valid_o,
  output logic          err_o,
  output logic [AW-1:0] addr_o
);

  localparam logic [XW:0] X_LIM = (XW+1)'(DIM_X);
  localparam logic [YW:0] Y_LIM = (YW+1)'(DIM_Y);
  localparam logic [ZW:0] Z_LIM = (ZW+1)'(DIM_Z);

  logic          oor;
  logic [AW-1:0] addr_d;
  logic          valid_q, err_q;
  logic [AW-1:0] addr_q;

  assign oor = ({1'b0, x_i} >= X_LIM) | ({1'b0, y_i} >= Y_LIM) | ({1'b0, z_i} >= Z_LIM);

  generate
    if (LAYOUT == LAYOUT_DENSE) begin : g_dense
      localparam int STRIDE_X = DIM_Y * DIM_Z;
      localparam int STRIDE_Y = DIM_Z;
      assign addr_d = AW'(x_i) * AW'(STRIDE_X) + AW'(y_i) * AW'(STRIDE_Y) + AW'(z_i);

      // R2
      dense_in_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_q && !err_q |-> ({1'b0, addr_q} < (AW+1)'(DEPTH)));
    end else begin : g_padded
      if (ZWU > 0) begin : g_xyz
        assign addr_d = {x_i, y_i, z_i};
      end else begin : g_xy
        assign addr_d = {x_i, y_i};
      end

      // R3
      padded_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_q && !err_q |->
          ({1'b0, addr_q[AW-1 -: XW]} < X_LIM) && ({1'b0, addr_q[ZWU +: YW]} < Y_LIM));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        err_q  <= oor;
        addr_q <= oor ? '0 : addr_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign addr_o  = addr_q;

endmodule

// File: rtl/tbl_rom_stage.sv
module tbl_rom_stage
  import tbl_map_pkg::*;
#(
  parameter tbl_layout_e LAYOUT = LAYOUT_DENSE,
  parameter int DIM_X  = 3,
  parameter int DIM_Y  = 4,
  parameter int DIM_Z  = 5,
  parameter int YW     = 2,
  parameter int ZW     = 3,
  parameter int ZWU    = 3,
  parameter int AW     = 6,
  parameter int DEPTH  = 60,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [AW-1:0]     addr_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o
);

  // Slot contents: decode the slot back to coordinates, zero for padding.
  function automatic logic [DATA_W-1:0] slot_word(input int a);
    int x, y, z;
    bit used;
    if (LAYOUT == LAYOUT_DENSE) begin
      x    = a / (DIM_Y * DIM_Z);
      y    = (a / DIM_Z) % DIM_Y;
      z    = a % DIM_Z;
      used = (a < DIM_X * DIM_Y * DIM_Z);
    end else begin
      z    = (ZWU > 0) ? (a & ((1 << ZW) - 1)) : 0;
      y    = (a >> ZWU) & ((1 << YW) - 1);
      x    = a >> (ZWU + YW);
      used = (x < DIM_X) && (y < DIM_Y) && (z < DIM_Z);
    end
    return used ? DATA_W'(tbl_word(x, y, z)) : '0;
  endfunction

  logic [DATA_W-1:0] rom_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_slot
    assign rom_w[a] = slot_word(a);
  end

  logic              valid_q, err_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        err_q  <= err_i;
        addr_q <= addr_i;
        data_q <= err_i ? '0 : rom_w[addr_i];
      end
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R4: an in-range read never lands on a padding slot
  live_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !err_q |-> data_q != '0);

endmodule

// File: rtl/tbl_map.sv
module tbl_map
  import tbl_map_pkg::*;
#(
  parameter tbl_layout_e LAYOUT = LAYOUT_DENSE,
  parameter int DIM_X  = 3,
  parameter int DIM_Y  = 4,
  parameter int DIM_Z  = 5,
  parameter int DATA_W = 8,
  localparam int XW          = (DIM_X > 1) ? $clog2(DIM_X) : 1,
  localparam int YW          = (DIM_Y > 1) ? $clog2(DIM_Y) : 1,
  localparam int ZW          = (DIM_Z > 1) ? $clog2(DIM_Z) : 1,
  localparam int ZWU         = (DIM_Z > 1) ? ZW : 0,
  localparam int PAD_AW      = XW + YW + ZWU,
  localparam int DENSE_DEPTH = DIM_X * DIM_Y * DIM_Z,
  localparam int DENSE_AW    = (DENSE_DEPTH > 1) ? $clog2(DENSE_DEPTH) : 1,
  localparam int AW          = (LAYOUT == LAYOUT_DENSE) ? DENSE_AW : PAD_AW,
  localparam int DEPTH       = (LAYOUT == LAYOUT_DENSE) ? DENSE_DEPTH : (1 << PAD_AW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [XW-1:0]     req_x_i,
  input  logic [YW-1:0]     req_y_i,
  input  logic [ZW-1:0]     req_z_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [AW-1:0]     rsp_addr_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  logic          s1_valid, s1_err;
  logic [AW-1:0] s1_addr;

  tbl_addr_stage #(
    .LAYOUT(LAYOUT), .DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z),
    .XW(XW), .YW(YW), .ZW(ZW), .ZWU(ZWU), .AW(AW), .DEPTH(DEPTH)
  ) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .x_i     (req_x_i),
    .y_i     (req_y_i),
    .z_i     (req_z_i),
    .valid_o (s1_valid),
    .err_o   (s1_err),
    .addr_o  (s1_addr)
  );

  tbl_rom_stage #(
    .LAYOUT(LAYOUT), .DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z),
    .YW(YW), .ZW(ZW), .ZWU(ZWU), .AW(AW), .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .err_i   (s1_err),
    .addr_i  (s1_addr),
    .valid_o (rsp_valid_o),
    .err_o   (rsp_err_o),
    .addr_o  (rsp_addr_o),
    .data_o  (rsp_data_o)
  );

  // Edges since reset release, saturating, for the latency check.
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  // R1
  latency_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst_q == 2'd2 |-> rsp_valid_o == $past(req_valid_i, 2));

  // R5
  err_zeroed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_data_o == '0 && rsp_addr_o == '0);

  // R7
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !rsp_valid_o);

endmodule

// File: tb/tbl_map_bench.sv
`timescale 1ns/1ps
module tbl_map_bench;
  import tbl_map_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_x = '0;
  logic [1:0] req_y = '0;
  logic [2:0] req_z = '0;

  always #2.5 clk = ~clk;

  // Dense 3x4x5
  logic       d_valid, d_err;
  logic [5:0] d_addr;
  logic [7:0] d_data;
  // Padded 3x4x5
  logic       p_valid, p_err;
  logic [6:0] p_addr;
  logic [7:0] p_data;
  // Padded 3x3 (two-dimensional)
  logic       q_valid, q_err;
  logic [3:0] q_addr;
  logic [7:0] q_data;

  tbl_map #(.LAYOUT(LAYOUT_DENSE), .DIM_X(3), .DIM_Y(4), .DIM_Z(5), .DATA_W(8)) u_tbl_map (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid),
    .req_x_i(req_x), .req_y_i(req_y), .req_z_i(req_z),
    .rsp_valid_o(d_valid), .rsp_err_o(d_err), .rsp_addr_o(d_addr), .rsp_data_o(d_data));

  tbl_map #(.LAYOUT(LAYOUT_PADDED), .DIM_X(3), .DIM_Y(4), .DIM_Z(5), .DATA_W(8)) u_tbl_map_pad (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid),
    .req_x_i(req_x), .req_y_i(req_y), .req_z_i(req_z),
    .rsp_valid_o(p_valid), .rsp_err_o(p_err), .rsp_addr_o(p_addr), .rsp_data_o(p_data));

  tbl_map #(.LAYOUT(LAYOUT_PADDED), .DIM_X(3), .DIM_Y(3), .DIM_Z(1), .DATA_W(8)) u_tbl_map_2d (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid),
    .req_x_i(req_x), .req_y_i(req_y), .req_z_i(1'b0),
    .rsp_valid_o(q_valid), .rsp_err_o(q_err), .rsp_addr_o(q_addr), .rsp_data_o(q_data));

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // {x[1:0], y[1:0], z[2:0]}
  localparam int NV = 14;
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 2'd0, 3'd0}, {2'd2, 2'd3, 3'd4}, {2'd1, 2'd2, 3'd3}, {2'd0, 2'd3, 3'd0},
    {2'd2, 2'd0, 3'd4}, {2'd1, 2'd1, 3'd1}, {2'd3, 2'd0, 3'd0}, {2'd0, 2'd0, 3'd5},
    {2'd2, 2'd3, 3'd7}, {2'd3, 2'd3, 3'd7}, {2'd2, 2'd2, 3'd2}, {2'd0, 2'd1, 3'd4},
    {2'd1, 2'd3, 3'd2}, {2'd2, 2'd2, 3'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req, input string what);
    chk(req, {what, " dense valid"}, int'(d_valid), 0);
    chk(req, {what, " padded valid"}, int'(p_valid), 0);
    chk(req, {what, " 2d valid"}, int'(q_valid), 0);
  endtask

  task automatic chk_rsp(input logic [6:0] v);
    int x, y, z, word, word2;
    bit e3, e2;
    x = int'(v[6:5]); y = int'(v[4:3]); z = int'(v[2:0]);
    e3 = (x >= 3) || (y >= 4) || (z >= 5);
    e2 = (x >= 3) || (y >= 3);
    word  = (x * 64 + y * 8 + z + 1) % 256;
    word2 = (x * 64 + y * 8 + 1) % 256;
    // R1 / R8: one response per request, in order
    chk("R8", "dense valid", int'(d_valid), 1);
    chk("R8", "padded valid", int'(p_valid), 1);
    chk("R8", "2d valid", int'(q_valid), 1);
    chk(e3 ? "R5" : "R6", "dense err", int'(d_err), int'(e3));
    chk(e3 ? "R5" : "R6", "padded err", int'(p_err), int'(e3));
    chk(e2 ? "R5" : "R6", "2d err", int'(q_err), int'(e2));
    chk(e3 ? "R5" : "R2", "dense addr", int'(d_addr), e3 ? 0 : x * 20 + y * 5 + z);
    chk(e3 ? "R5" : "R3", "padded addr", int'(p_addr), e3 ? 0 : x * 32 + y * 8 + z);
    chk(e2 ? "R5" : "R3", "2d addr", int'(q_addr), e2 ? 0 : x * 4 + y);
    chk(e3 ? "R5" : "R4", "dense data", int'(d_data), e3 ? 0 : word);
    chk(e3 ? "R5" : "R4", "padded data", int'(p_data), e3 ? 0 : word);
    chk(e2 ? "R5" : "R4", "2d data", int'(q_data), e2 ? 0 : word2);
  endtask

  task automatic drive(input logic vld, input logic [6:0] v);
    req_valid = vld;
    req_x = v[6:5];
    req_y = v[4:3];
    req_z = v[2:0];
  endtask

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    chk_idle("R7", "in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R7", "after release");

    // Back-to-back stream, responses checked two cycles after each request
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) chk_rsp(VEC[i-2]);
      else        chk_idle("R1", "pre-stream");
      if (i < NV) drive(1'b1, VEC[i]);
      else        drive(1'b0, '0);
    end
    @(negedge clk);
    chk_idle("R1", "post-stream");

    // R1: isolated request, exact latency
    drive(1'b1, {2'd1, 2'd0, 3'd2});
    @(negedge clk);
    drive(1'b0, '0);
    chk_idle("R1", "one edge later");
    @(negedge clk);
    chk_rsp({2'd1, 2'd0, 3'd2});
    @(negedge clk);
    chk_idle("R1", "three edges later");

    // R7: request in flight when reset asserts
    drive(1'b1, {2'd2, 2'd1, 3'd3});
    @(negedge clk);
    drive(1'b0, '0);
    rst_ni = 1'b0;
    #0.5;
    chk_idle("R7", "async assert");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_idle("R7", "flushed request");
    end

    // Corner: largest legal and first illegal coordinates after reset
    drive(1'b1, {2'd2, 2'd3, 3'd4});
    @(negedge clk);
    drive(1'b1, {2'd2, 2'd3, 3'd5});
    @(negedge clk);
    drive(1'b0, '0);
    chk_rsp({2'd2, 2'd3, 3'd4});
    @(negedge clk);
    chk_rsp({2'd2, 2'd3, 3'd5});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule